// File: doc/BRIEF.md
# Write-Strobed Video Control Register

This block sits on the address bus of a small 8-bit processor and holds the control state a video generator needs: a 3-bit display mode and a 7-bit display offset. The processor does not write values into these fields. Each field bit is controlled by its own pair of bus addresses inside a 32-byte window at the top of the address map. A write to the even address of a pair clears that bit, and a write to the odd address sets it. The byte on the data bus plays no part in the update. Both fields are driven continuously to the video side. A display start address, the offset scaled by 512, is driven beside them.

The same block also moves the processor's interrupt-vector fetches. A read that falls in the last fourteen bytes of the address space is passed on to memory with address bit 14 forced low. The vector bytes are therefore fetched from the ROM image that lies 16 KiB lower. Every other access passes through with its address unchanged.

Top module: `vidctl_top`

## Requirements
- R1: A write counts only when `addr[15:5]` equals 0x7FE, which is the window 0xFFC0 to 0xFFDF. A strobed write to any address outside this window leaves both fields unchanged.
- R2: Window offsets 0x00 to 0x05 control the mode bits. Mode bit k is at pair k. The even offset 2k clears the bit and the odd offset 2k+1 sets it.
- R3: Window offsets 0x06 to 0x13 control the offset bits. Offset bit k is cleared by window offset 2k+6 and set by window offset 2k+7, for k from 0 to 6.
- R4: The value on `wdata` has no effect. A set with data 0x00 still sets the bit, and a clear with data 0xFF still clears it.
- R5: The fields change only on a rising clock edge where `cs` and `we` are both high. If `cs` is low, or `we` is low, nothing changes, even when `rd` is high.
- R6: After reset, `vmode` is 0 and `voffset` is 2, so `vstart` is 0x0400.
- R7: Writes to window offsets 0x14 to 0x1F are accepted but change neither field.
- R8: `vstart` always equals `voffset` multiplied by 512, as a 16-bit value. An update shows on `vmode`, `voffset` and `vstart` right after the clock edge that samples the write.
- R9: While `rd` is high and `addr` is in 0xFFF2 to 0xFFFF, `mem_addr` equals `addr` with bit 14 cleared. This path is combinational.
- R10: In every other case, `mem_addr` equals `addr`. This covers a read of 0xFFF1 and a non-read access to the vector range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| cs | input | 1 | Chip select for the register window |
| we | input | 1 | Write strobe |
| rd | input | 1 | Read strobe; controls the vector remap |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Processor write data; has no effect |
| mem_addr | output | 16 | Address passed on to memory after the vector remap |
| vmode | output | 3 | Display mode field |
| voffset | output | 7 | Display offset field |
| vstart | output | 16 | Display start address (offset × 512) |

## Verification
A wrong decode or a wrong bit-register state shows up on `vmode` or `voffset` in the cycle right after the write edge. The bench compares all three video outputs after every single write. A write that reaches the wrong bit, or that moves a neighbouring bit, is therefore caught at that write and does not wait until later traffic exposes it. The bench walks all 32 window offsets in both the set and clear directions, so any swapped pair or off-by-one pair index changes a field value it compares. The remap is checked in the same cycle the address is driven, because it is purely combinational.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;

  // action carried by the low address bit of a pair
  typedef enum logic {
    ACT_CLEAR = 1'b0,
    ACT_SET   = 1'b1
  } act_e;

  localparam int unsigned WIN_SEL_W = 5;

endpackage

// File: rtl/vidctl_rst_sync.sv
module vidctl_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic [1:0] stage;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      stage <= 2'b00;
    end else begin
      stage <= {stage[0], 1'b1};
    end
  end

  assign rst_n_s = stage[1];

endmodule

// File: rtl/vidctl_decode.sv
module vidctl_decode
  import vidctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned NBITS    = 10,
  parameter logic [15:0] WIN_BASE = 16'hFFC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [NBITS-1:0]  set_o,
  output logic [NBITS-1:0]  clr_o
);

  localparam int unsigned PAIR_W = WIN_SEL_W - 1;
  localparam int unsigned HI_W   = ADDR_W - WIN_SEL_W;

  logic              in_win;
  logic              wr_hit;
  logic [PAIR_W-1:0] pair;
  act_e              act;

  assign in_win = (addr[ADDR_W-1:WIN_SEL_W] == WIN_BASE[ADDR_W-1:WIN_SEL_W]);
  assign wr_hit = cs && we && in_win;
  assign pair   = addr[WIN_SEL_W-1:1];
  assign act    = act_e'(addr[0]);

  for (genvar i = 0; i < NBITS; i++) begin : g_strobe
    logic pick;
    assign pick     = wr_hit && (pair == PAIR_W'(i));
    assign set_o[i] = pick && (act == ACT_SET);
    assign clr_o[i] = pick && (act == ACT_CLEAR);
  end

  // at most one bit action per bus write
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_o, clr_o})); // R2

  // a write outside the window never produces a strobe
  AST_WIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:WIN_SEL_W] != HI_W'(WIN_BASE >> WIN_SEL_W)) |-> !(|{set_o, clr_o})); // R1

endmodule

// File: rtl/vidctl_bitreg.sv
module vidctl_bitreg #(
  parameter int unsigned          NBITS   = 10,
  parameter logic [NBITS-1:0]     RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_i,
  input  logic [NBITS-1:0] clr_i,
  output logic [NBITS-1:0] q
);

  logic [NBITS-1:0] q_nxt;
  logic             q_en;

  assign q_en = |{set_i, clr_i};

  always_comb begin
    q_nxt = q;
    for (int i = 0; i < NBITS; i++) begin
      if (set_i[i]) begin
        q_nxt[i] = 1'b1;
      end else if (clr_i[i]) begin
        q_nxt[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_chk
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q[i]); // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[i] |=> !q[i]); // R3
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(|{set_i, clr_i}) |=> $stable(q)); // R5

endmodule

// File: rtl/vidctl_top.sv
module vidctl_top
  import vidctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned MODE_W      = 3,
  parameter int unsigned OFFS_W      = 7,
  parameter int unsigned MODE_RST    = 0,
  parameter int unsigned OFFS_RST    = 2,
  parameter int unsigned START_SHIFT = 9,
  parameter int unsigned REMAP_BIT   = 14,
  parameter logic [15:0] WIN_BASE    = 16'hFFC0,
  parameter logic [15:0] VEC_LO      = 16'hFFF2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [MODE_W-1:0] vmode,
  output logic [OFFS_W-1:0] voffset,
  output logic [ADDR_W-1:0] vstart
);

  localparam int unsigned       NBITS   = MODE_W + OFFS_W;
  localparam logic [NBITS-1:0]  RST_VAL = {OFFS_W'(OFFS_RST), MODE_W'(MODE_RST)};

  logic             rst_n_s;
  logic [NBITS-1:0] set_v;
  logic [NBITS-1:0] clr_v;
  logic [NBITS-1:0] q;
  logic             vec_rd;

  vidctl_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  vidctl_decode #(
    .ADDR_W   (ADDR_W),
    .NBITS    (NBITS),
    .WIN_BASE (WIN_BASE)
  ) u_dec (
    .clk   (clk),
    .rst_n (rst_n_s),
    .cs    (cs),
    .we    (we),
    .addr  (addr),
    .set_o (set_v),
    .clr_o (clr_v)
  );

  vidctl_bitreg #(
    .NBITS   (NBITS),
    .RST_VAL (RST_VAL)
  ) u_reg (
    .clk   (clk),
    .rst_n (rst_n_s),
    .set_i (set_v),
    .clr_i (clr_v),
    .q     (q)
  );

  assign vmode   = q[MODE_W-1:0];
  assign voffset = q[NBITS-1:MODE_W];
  assign vstart  = ADDR_W'(voffset) << START_SHIFT;

  // vector window remap, combinational
  assign vec_rd = rd && (addr >= ADDR_W'(VEC_LO));

  always_comb begin
    mem_addr = addr;
    if (vec_rd) begin
      mem_addr[REMAP_BIT] = 1'b0;
    end
  end

  AST_VEC_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd && addr >= ADDR_W'(VEC_LO)) |-> (!mem_addr[REMAP_BIT] && mem_addr[REMAP_BIT-1:0] == addr[REMAP_BIT-1:0])); // R9

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd |-> (mem_addr == addr)); // R10

  AST_WDATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cs && we) |-> !$isunknown(wdata)); // R4

  AST_RST_VALUE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (vmode == MODE_W'(MODE_RST) && voffset == OFFS_W'(OFFS_RST))); // R6

endmodule

// File: tb/vidctl_top_tb.sv
`timescale 1ns/1ps
module vidctl_top_tb;

  logic        clk;
  logic        rst_n;
  logic        cs;
  logic        we;
  logic        rd;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic [15:0] mem_addr;
  logic [2:0]  vmode;
  logic [6:0]  voffset;
  logic [15:0] vstart;

  typedef struct packed {
    logic [2:0]  m;
    logic [6:0]  o;
    logic [15:0] s;
    logic [15:0] a;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  int    n_chk;
  int    n_fail;
  bit    done;

  logic [2:0] mdl_mode;
  logic [6:0] mdl_offs;

  vidctl_top u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .we       (we),
    .rd       (rd),
    .addr     (addr),
    .wdata    (wdata),
    .mem_addr (mem_addr),
    .vmode    (vmode),
    .voffset  (voffset),
    .vstart   (vstart)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string tag_of(input logic [4:0] sel);
    if (sel < 5'h06)      return "R2";
    else if (sel < 5'h14) return "R3";
    else                  return "R7";
  endfunction

  task automatic push(input string tag, input logic [15:0] a_exp);
    exp_t e;
    e.m = mdl_mode;
    e.o = mdl_offs;
    e.s = {mdl_offs, 9'b0};
    e.a = a_exp;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                          input logic c, input logic w, input logic r, input string tag);
    @(posedge clk); #1;
    cs = c; we = w; rd = r; addr = a; wdata = d;
    @(posedge clk); #1;
    cs = 1'b0; we = 1'b0; rd = 1'b0;
    if (c && w && a[15:5] == 11'h7FE) begin
      int k;
      k = int'(a[4:1]);
      if (k < 3)       mdl_mode[k]   = a[0];
      else if (k < 10) mdl_offs[k-3] = a[0];
    end
    push(tag, a);
  endtask

  task automatic do_read(input logic [15:0] a, input logic r, input string tag);
    @(posedge clk); #1;
    cs = 1'b0; we = 1'b0; rd = r; addr = a;
    push(tag, (r && a >= 16'hFFF2) ? (a & 16'hBFFF) : a);
  endtask

  // monitor: compares every queued expectation at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (vmode !== e.m || voffset !== e.o || vstart !== e.s || mem_addr !== e.a) begin
          n_fail++;
          $display("FAIL %s: got mode=%0h offs=%0h start=%04h mem=%04h, expected mode=%0h offs=%0h start=%04h mem=%04h",
                   t, vmode, voffset, vstart, mem_addr, e.m, e.o, e.s, e.a);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hung, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    cs = 1'b0; we = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    mdl_mode = 3'd0; mdl_offs = 7'd2;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    do_read(16'h0000, 1'b0, "R6 reset value");

    // R2 mode pairs
    do_write(16'hFFC1, 8'h00, 1, 1, 0, "R2 set mode0");
    do_write(16'hFFC5, 8'h00, 1, 1, 0, "R2 set mode2");
    do_write(16'hFFC0, 8'hFF, 1, 1, 0, "R2 clear mode0");
    do_write(16'hFFC3, 8'h5A, 1, 1, 0, "R2 set mode1");
    // R3 offset pairs and R8 start address
    do_write(16'hFFC8, 8'h00, 1, 1, 0, "R3 clear offs1");
    do_write(16'hFFD3, 8'h00, 1, 1, 0, "R3 set offs6 R8");
    do_write(16'hFFC7, 8'h00, 1, 1, 0, "R3 set offs0 R8");
    // R4 data ignored
    do_write(16'hFFCB, 8'h00, 1, 1, 0, "R4 set with zero data");
    do_write(16'hFFCA, 8'hFF, 1, 1, 0, "R4 clear with ones data");
    // R5 strobes required
    do_write(16'hFFCD, 8'hFF, 0, 1, 0, "R5 cs low");
    do_write(16'hFFCD, 8'hFF, 1, 0, 1, "R5 we low");
    // R1 outside window
    do_write(16'hFFA9, 8'h00, 1, 1, 0, "R1 below window");
    do_write(16'h7FC9, 8'h00, 1, 1, 0, "R1 top bit differs");
    do_write(16'hFFE1, 8'h00, 1, 1, 0, "R1 above window");
    // R7 unused offsets
    for (int i = 20; i < 32; i++) begin
      do_write(16'hFFC0 | 16'(i), 8'hFF, 1, 1, 0, "R7 unused offset");
    end
    // full walk: every set then every clear
    for (int i = 1; i < 32; i += 2) begin
      do_write(16'hFFC0 | 16'(i), 8'h00, 1, 1, 0, tag_of(5'(i)));
    end
    for (int i = 0; i < 32; i += 2) begin
      do_write(16'hFFC0 | 16'(i), 8'hFF, 1, 1, 0, tag_of(5'(i)));
    end
    // R9 / R10 remap
    do_read(16'hFFF2, 1'b1, "R9 low vector");
    do_read(16'hFFFF, 1'b1, "R9 top vector");
    do_read(16'hFFF8, 1'b1, "R9 mid vector");
    do_read(16'hFFF1, 1'b1, "R10 just below range");
    do_read(16'hFFF4, 1'b0, "R10 non-read in range");
    do_read(16'h1234, 1'b1, "R10 ordinary read");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule